// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Engine

This block sits between a processor's atomic request port and a single-port synchronous memory. It runs one compare-and-swap transaction at a time. A request names an operand size (32, 64 or 128 bits), a byte address, a compare value, a swap value, a writable-region flag and two ordering flags. The engine reads the operand from memory and compares it bit for bit with the compare value. It writes the swap value back only when the two are equal. It then returns the old value together with a success bit, fault bits and the ordering that the operation carries.

The memory word is `XLEN` bits wide and has a read latency of one cycle. An operand twice the memory width takes two beats, with the low half at the base address and the high half at the next word. An operand half the memory width uses byte strobes on one lane. A lock output stays high from the first read until the final write or the decision to skip it. A shared memory arbiter can use this lock to keep other requesters out. A parameter chooses what happens on a failed compare: the write is skipped (default), or the old value is written back.

Top module: `amo_cas_engine`

## Requirements
- R1: Size codes are 0 = 32-bit, 1 = 64-bit, 2 = 128-bit and 3 = reserved. Code 3, or any operand wider than two memory words, sets `rsp_unsupported`, clears `rsp_ok` and causes no memory cycle.
- R2: A supported request whose address is not a multiple of the operand size in bytes (4, 8 or 16) sets `rsp_misalign`, clears `rsp_ok` and causes no memory cycle.
- R3: A request with `req_writable` low sets `rsp_access_fault` and causes no memory cycle, even when the compare would have failed.
- R4: Only the operand's bits take part in the compare: the low 32 bits of `req_cmp` for size 0, the low 64 bits for size 1, and all 128 bits for size 2. A two-beat operand succeeds only when both halves match.
- R5: On a match the swap value is written at the operand address. For a two-beat operand, bits [63:0] go to the base word and bits [127:64] go to the word at byte offset +8.
- R6: `rsp_old` always returns the loaded value. Size 0 is sign-extended to 64 bits, size 1 fills [63:0], and the unused upper bits read zero.
- R7: With the default failure policy, a failed compare issues no write cycle and leaves memory unchanged.
- R8: On a completed, non-faulting operation `rsp_acquire` equals the request's acquire flag. `rsp_release` is high only when the release flag was set and the compare succeeded. Both are low on a fault.
- R9: `mem_lock` is high on every memory cycle of a transaction, from its first read through its last write.
- R10: Only one transaction is in flight. `req_ready` falls after acceptance and returns only after `rsp_valid`, which lasts exactly one cycle.
- R11: A 32-bit operand on a 64-bit memory touches only the 4-byte lane selected by address bit 2. Its write strobes cover exactly that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W (16) | Byte address |
| req_cmp | input | 2*XLEN (128) | Compare value |
| req_swap | input | 2*XLEN (128) | Swap value |
| req_acquire | input | 1 | Acquire ordering requested |
| req_release | input | 1 | Release ordering requested |
| req_writable | input | 1 | Target region grants write permission |
| rsp_valid | output | 1 | Response pulse |
| rsp_old | output | 2*XLEN (128) | Loaded value |
| rsp_ok | output | 1 | Compare matched and swap written |
| rsp_misalign | output | 1 | Alignment fault |
| rsp_access_fault | output | 1 | Write-permission fault |
| rsp_unsupported | output | 1 | Size not supported |
| rsp_acquire | output | 1 | Operation carries acquire ordering |
| rsp_release | output | 1 | Operation carries release ordering |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-log2(XLEN/8) (13) | Memory word address |
| mem_wdata | output | XLEN (64) | Write data |
| mem_strb | output | XLEN/8 (8) | Byte write strobes |
| mem_rdata | input | XLEN (64) | Read data, one cycle after a read |
| mem_lock | output | 1 | Exclusive hold on the memory |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the read and that no other agent writes it while `mem_lock` is high. They also assume that `req_valid` is raised only while the engine is idle. The bench owns the only memory model and drives it solely through the engine's port. It presents each request for a single cycle while `req_ready` is high and waits for the response before sending the next. Random addresses stay inside a 512-byte window that the model covers, so every aligned access lands on modelled storage.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0,
    ST_RD1,
    ST_EVAL,
    ST_WR0,
    ST_WR1,
    ST_RESP
  } cas_state_e;

  // operand width in bytes for a size code: 4, 8, 16 (32 for the reserved code)
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    return 32'd4 << sz;
  endfunction

  // a size is usable when it is not reserved and fits in two memory words
  function automatic logic size_legal(input logic [1:0] sz, input int unsigned word_bytes);
    return (sz != 2'd3) && (size_bytes(sz) <= 2 * word_bytes);
  endfunction

  // natural alignment test on the low address bits
  function automatic logic addr_aligned(input logic [3:0] lo, input logic [1:0] sz);
    logic [3:0] m;
    m = 4'(size_bytes(sz) - 32'd1);
    return (lo & m) == 4'd0;
  endfunction

endpackage

// File: rtl/cas_req_decode.sv
module cas_req_decode
  import cas_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 16
) (
  input  logic [1:0]                           size,
  input  logic [ADDR_W-1:0]                    addr,
  input  logic                                 writable,
  output logic                                 unsup,
  output logic                                 misalign,
  output logic                                 acc_fault,
  output logic                                 two_beat,
  output logic                                 sub_lane,
  output logic                                 lane,
  output logic [ADDR_W-$clog2(XLEN/8)-1:0]     beat0
);
  localparam int unsigned BYTES = XLEN / 8;
  localparam int          OFF_W = $clog2(BYTES);

  always_comb begin
    unsup     = !size_legal(size, BYTES);
    misalign  = !unsup && !addr_aligned(addr[3:0], size);
    acc_fault = !writable;
    two_beat  = !unsup && (size_bytes(size) > BYTES);
    sub_lane  = !unsup && (size_bytes(size) < BYTES);
    beat0     = addr[ADDR_W-1:OFF_W];
  end

  generate
    if (XLEN > 32) begin : g_lane
      assign lane = addr[2];
    end else begin : g_nolane
      assign lane = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cas_lane_unit.sv
module cas_lane_unit #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]   rd_beat,
  input  logic              sub,
  input  logic              lane,
  input  logic [XLEN-1:0]   wr_word,
  output logic [XLEN-1:0]   rd_val,
  output logic [XLEN-1:0]   wr_beat,
  output logic [XLEN/8-1:0] wr_strb
);
  localparam int BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] LOW32 = XLEN'(32'hFFFF_FFFF);

  logic [XLEN-1:0] shifted;

  always_comb begin
    shifted = rd_beat >> {lane, 5'd0};
    rd_val  = sub ? (shifted & LOW32) : rd_beat;
    for (int i = 0; i < XLEN; i++) begin
      wr_beat[i] = sub ? wr_word[i % 32] : wr_word[i];
    end
    for (int b = 0; b < BYTES; b++) begin
      wr_strb[b] = sub ? ((b / 4) == int'(lane)) : 1'b1;
    end
  end

endmodule

// File: rtl/amo_cas_engine.sv
module amo_cas_engine
  import cas_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int ADDR_W  = 16,
  parameter int FAIL_WB = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic [1:0]                          req_size,
  input  logic [ADDR_W-1:0]                   req_addr,
  input  logic [2*XLEN-1:0]                   req_cmp,
  input  logic [2*XLEN-1:0]                   req_swap,
  input  logic                                req_acquire,
  input  logic                                req_release,
  input  logic                                req_writable,
  output logic                                rsp_valid,
  output logic [2*XLEN-1:0]                   rsp_old,
  output logic                                rsp_ok,
  output logic                                rsp_misalign,
  output logic                                rsp_access_fault,
  output logic                                rsp_unsupported,
  output logic                                rsp_acquire,
  output logic                                rsp_release,
  output logic                                mem_en,
  output logic                                mem_we,
  output logic [ADDR_W-$clog2(XLEN/8)-1:0]    mem_addr,
  output logic [XLEN-1:0]                     mem_wdata,
  output logic [XLEN/8-1:0]                   mem_strb,
  input  logic [XLEN-1:0]                     mem_rdata,
  output logic                                mem_lock
);
  localparam int BYTES = XLEN / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int MAW   = ADDR_W - OFF_W;
  localparam int OPW   = 2 * XLEN;

  cas_state_e state;

  logic [MAW-1:0] beat_q;
  logic           two_q, sub_q, lane_q, acq_q, rel_q;
  logic           unsup_q, mis_q, acc_q, match_q;
  logic [OPW-1:0] cmp_q, swap_q, old_q;

  logic           d_unsup, d_mis, d_acc, d_two, d_sub, d_lane;
  logic [MAW-1:0] d_beat;

  cas_req_decode #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dec (
    .size(req_size), .addr(req_addr), .writable(req_writable),
    .unsup(d_unsup), .misalign(d_mis), .acc_fault(d_acc),
    .two_beat(d_two), .sub_lane(d_sub), .lane(d_lane), .beat0(d_beat)
  );

  // named events for the checker
  logic accept, accept_fault, cmp_hit, fault_any;
  assign accept       = req_valid && req_ready;
  assign accept_fault = accept && (d_unsup || d_mis || d_acc);
  assign cmp_hit      = match_q;
  assign fault_any    = unsup_q || mis_q || acc_q;

  logic [OPW-1:0]  src;
  logic [XLEN-1:0] wr_word, rd_val, wr_beat;
  logic [BYTES-1:0] wr_strb;

  assign src     = match_q ? swap_q : old_q;
  assign wr_word = (state == ST_WR1) ? src[OPW-1:XLEN] : src[XLEN-1:0];

  cas_lane_unit #(.XLEN(XLEN)) u_lane (
    .rd_beat(mem_rdata), .sub(sub_q), .lane(lane_q), .wr_word(wr_word),
    .rd_val(rd_val), .wr_beat(wr_beat), .wr_strb(wr_strb)
  );

  logic [OPW-1:0] op_mask, eval_old;
  logic           eval_hit;

  always_comb begin
    for (int i = 0; i < OPW; i++) begin
      op_mask[i] = two_q | (sub_q ? (i < 32) : (i < XLEN));
    end
    eval_old = two_q ? {rd_val, old_q[XLEN-1:0]} : {{XLEN{1'b0}}, rd_val};
    eval_hit = ((eval_old ^ cmp_q) & op_mask) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      beat_q  <= '0;
      two_q   <= 1'b0;
      sub_q   <= 1'b0;
      lane_q  <= 1'b0;
      acq_q   <= 1'b0;
      rel_q   <= 1'b0;
      unsup_q <= 1'b0;
      mis_q   <= 1'b0;
      acc_q   <= 1'b0;
      match_q <= 1'b0;
      cmp_q   <= '0;
      swap_q  <= '0;
      old_q   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          beat_q  <= d_beat;
          two_q   <= d_two;
          sub_q   <= d_sub;
          lane_q  <= d_lane;
          acq_q   <= req_acquire;
          rel_q   <= req_release;
          unsup_q <= d_unsup;
          mis_q   <= d_mis;
          acc_q   <= d_acc;
          match_q <= 1'b0;
          cmp_q   <= req_cmp;
          swap_q  <= req_swap;
          old_q   <= '0;
          state   <= accept_fault ? ST_RESP : ST_RD0;
        end
        ST_RD0: state <= two_q ? ST_RD1 : ST_EVAL;
        ST_RD1: begin
          old_q[XLEN-1:0] <= rd_val;
          state           <= ST_EVAL;
        end
        ST_EVAL: begin
          old_q   <= eval_old;
          match_q <= eval_hit;
          state   <= (eval_hit || FAIL_WB != 0) ? ST_WR0 : ST_RESP;
        end
        ST_WR0: state <= two_q ? ST_WR1 : ST_RESP;
        ST_WR1: state <= ST_RESP;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    mem_en    = (state == ST_RD0) || (state == ST_RD1) ||
                (state == ST_WR0) || (state == ST_WR1);
    mem_we    = (state == ST_WR0) || (state == ST_WR1);
    mem_lock  = mem_en || (state == ST_EVAL);
    mem_addr  = ((state == ST_RD1) || (state == ST_WR1)) ? beat_q + MAW'(1) : beat_q;
    mem_wdata = wr_beat;
    mem_strb  = mem_we ? wr_strb : '0;

    rsp_valid        = (state == ST_RESP);
    rsp_ok           = match_q && !fault_any;
    rsp_misalign     = mis_q;
    rsp_access_fault = acc_q;
    rsp_unsupported  = unsup_q;
    rsp_acquire      = acq_q && !fault_any;
    rsp_release      = rel_q && match_q && !fault_any;
    for (int i = 0; i < OPW; i++) begin
      rsp_old[i] = (sub_q && i >= 32 && i < XLEN) ? old_q[31] : old_q[i];
    end
  end

endmodule

// File: rtl/cas_engine_checker.sv
module cas_engine_checker #(
  parameter int FAIL_WB = 0,
  parameter int BYTES   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             rsp_misalign,
  input logic             rsp_access_fault,
  input logic             rsp_unsupported,
  input logic             rsp_acquire,
  input logic             rsp_release,
  input logic             mem_en,
  input logic             mem_we,
  input logic [BYTES-1:0] mem_strb,
  input logic             mem_lock,
  input logic             cmp_hit,
  input logic             accept_fault
);

  assert_lock_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_lock);

  assert_release_needs_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_release) |-> rsp_ok);

  assert_fault_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_misalign || rsp_access_fault || rsp_unsupported))
      |-> (!rsp_ok && !rsp_acquire && !rsp_release));

  assert_fault_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fault |=> !mem_en);

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_strobe_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_strb) == 4 || $countones(mem_strb) == BYTES));

  generate
    if (FAIL_WB == 0) begin : g_skip
      assert_skip_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> cmp_hit);
    end
  endgenerate

endmodule

bind amo_cas_engine cas_engine_checker #(.FAIL_WB(FAIL_WB), .BYTES(XLEN/8)) u_cas_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_misalign(rsp_misalign),
  .rsp_access_fault(rsp_access_fault), .rsp_unsupported(rsp_unsupported),
  .rsp_acquire(rsp_acquire), .rsp_release(rsp_release),
  .mem_en(mem_en), .mem_we(mem_we), .mem_strb(mem_strb), .mem_lock(mem_lock),
  .cmp_hit(cmp_hit), .accept_fault(accept_fault)
);

// File: tb/amo_cas_engine_bench.sv
`timescale 1ns/1ps
module amo_cas_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         req_valid = 1'b0, req_ready;
  logic [1:0]   req_size = '0;
  logic [15:0]  req_addr = '0;
  logic [127:0] req_cmp = '0, req_swap = '0;
  logic         req_acquire = 1'b0, req_release = 1'b0, req_writable = 1'b0;
  logic         rsp_valid, rsp_ok, rsp_misalign, rsp_access_fault, rsp_unsupported;
  logic         rsp_acquire, rsp_release;
  logic [127:0] rsp_old;
  logic         mem_en, mem_we, mem_lock;
  logic [12:0]  mem_addr;
  logic [63:0]  mem_wdata, mem_rdata;
  logic [7:0]   mem_strb;

  amo_cas_engine u_amo_cas_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_addr(req_addr), .req_cmp(req_cmp), .req_swap(req_swap),
    .req_acquire(req_acquire), .req_release(req_release), .req_writable(req_writable),
    .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_ok(rsp_ok),
    .rsp_misalign(rsp_misalign), .rsp_access_fault(rsp_access_fault),
    .rsp_unsupported(rsp_unsupported), .rsp_acquire(rsp_acquire),
    .rsp_release(rsp_release), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_strb(mem_strb),
    .mem_rdata(mem_rdata), .mem_lock(mem_lock)
  );

  logic [63:0] mem_arr [64];
  logic [63:0] exp_mem [64];
  int rd_cnt = 0, wr_cnt = 0, lock_err = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (!mem_lock) lock_err = lock_err + 1;
      if (mem_we) begin
        wr_cnt = wr_cnt + 1;
        for (int b = 0; b < 8; b++)
          if (mem_strb[b]) mem_arr[mem_addr[5:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        rd_cnt = rd_cnt + 1;
      end
      mem_rdata <= mem_arr[mem_addr[5:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [127:0] cur_val(input logic [1:0] sz, input logic [15:0] a);
    int idx = int'(a[8:3]);
    case (sz)
      2'd0:    return {96'd0, (a[2] ? exp_mem[idx][63:32] : exp_mem[idx][31:0])};
      2'd1:    return {64'd0, exp_mem[idx]};
      default: return {exp_mem[(idx | 1)], exp_mem[idx & 62]};
    endcase
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic [15:0] a,
                        input logic [127:0] cmp, input logic [127:0] swp,
                        input logic aq, input logic rl, input logic wr);
    int opb, idx, nrd, nwr;
    logic unsup, mis, acc, flt, hit, got;
    logic [127:0] old, rsp;
    opb = 4 << sz;
    unsup = (sz == 2'd3);
    mis = !unsup && ((int'(a) % opb) != 0);
    acc = !wr;
    flt = unsup || mis || acc;
    idx = int'(a[8:3]);
    old = '0; rsp = '0; hit = 1'b0; nrd = 0; nwr = 0;
    if (!flt) begin
      old = cur_val(sz, a);
      case (sz)
        2'd0: begin
          hit = (old[31:0] == cmp[31:0]);
          rsp = {64'd0, {32{old[31]}}, old[31:0]};
          nrd = 1;
          if (hit) begin
            nwr = 1;
            if (a[2]) exp_mem[idx][63:32] = swp[31:0];
            else      exp_mem[idx][31:0]  = swp[31:0];
          end
        end
        2'd1: begin
          hit = (old[63:0] == cmp[63:0]);
          rsp = old; nrd = 1;
          if (hit) begin nwr = 1; exp_mem[idx] = swp[63:0]; end
        end
        default: begin
          hit = (old == cmp);
          rsp = old; nrd = 2;
          if (hit) begin nwr = 2; exp_mem[idx] = swp[63:0]; exp_mem[idx+1] = swp[127:64]; end
        end
      endcase
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", {127'd0, req_ready}, 128'd1);
    req_valid = 1'b1; req_size = sz; req_addr = a; req_cmp = cmp; req_swap = swp;
    req_acquire = aq; req_release = rl; req_writable = wr;
    rd_cnt = 0; wr_cnt = 0; lock_err = 0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready low while busy", {127'd0, req_ready}, 128'd0);
    got = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (rsp_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk(got, "R10", "response arrived", {127'd0, got}, 128'd1);
    chk(rsp_unsupported == unsup, "R1", "unsupported flag", {127'd0, rsp_unsupported}, {127'd0, unsup});
    chk(rsp_misalign == mis, "R2", "misalign flag", {127'd0, rsp_misalign}, {127'd0, mis});
    chk(rsp_access_fault == acc, "R3", "access fault flag", {127'd0, rsp_access_fault}, {127'd0, acc});
    chk(rsp_ok == (hit && !flt), "R4", "success bit", {127'd0, rsp_ok}, {127'd0, hit && !flt});
    chk(rsp_old == rsp, "R6", "old value", rsp_old, rsp);
    chk({rsp_acquire, rsp_release} == {aq && !flt, rl && hit && !flt}, "R8", "ordering bits",
        {126'd0, rsp_acquire, rsp_release}, {126'd0, aq && !flt, rl && hit && !flt});
    chk(rd_cnt == nrd, flt ? "R3" : "R5", "read cycles", 128'(rd_cnt), 128'(nrd));
    chk(wr_cnt == nwr, "R7", "write cycles", 128'(wr_cnt), 128'(nwr));
    chk(lock_err == 0, "R9", "unlocked memory cycles", 128'(lock_err), 128'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10", "response pulse length", {127'd0, rsp_valid}, 128'd0);
    for (int w = 0; w < 64; w++) begin
      if (mem_arr[w] !== exp_mem[w]) begin
        chk(1'b0, (sz == 2'd0) ? "R11" : "R5", "memory word", {64'd0, mem_arr[w]}, {64'd0, exp_mem[w]});
        break;
      end
    end
    checks++;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    void'($urandom(32'd4242));
    for (int w = 0; w < 64; w++) begin
      mem_arr[w] = {$urandom, $urandom};
      exp_mem[w] = mem_arr[w];
    end
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R10", "reset handshake state", {126'd0, req_ready, rsp_valid}, 128'd2);
    chk(!mem_en && !mem_lock, "R9", "reset memory idle", {126'd0, mem_en, mem_lock}, 128'd0);

    // R5: quadword success, high half at +8
    run_op(2'd2, 16'h0040, cur_val(2'd2, 16'h0040), 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0, 1'b1, 1'b1);
    // R4: only the high half differs, so the compare fails
    v = cur_val(2'd2, 16'h0040) ^ (128'd1 << 100);
    run_op(2'd2, 16'h0040, v, '1, 1'b1, 1'b1, 1'b1);
    // R6: negative word in the upper lane sign-extends
    run_op(2'd1, 16'h0080, cur_val(2'd1, 16'h0080), 128'h8000_0001_1234_5678, 1'b0, 1'b0, 1'b1);
    run_op(2'd0, 16'h0084, 128'd0, 128'd7, 1'b0, 1'b0, 1'b1);
    // R11: upper-lane word write leaves the lower lane intact
    run_op(2'd0, 16'h0084, 128'h8000_0001, 128'h5555_AAAA, 1'b1, 1'b1, 1'b1);
    run_op(2'd0, 16'h0080, 128'h1234_5678, 128'h0BAD_F00D, 1'b0, 1'b0, 1'b1);
    // R2: misaligned doubleword and word
    run_op(2'd1, 16'h0044, cur_val(2'd1, 16'h0040), 128'd1, 1'b1, 1'b1, 1'b1);
    run_op(2'd0, 16'h0006, 128'd0, 128'd1, 1'b0, 1'b0, 1'b1);
    // R1: reserved size code
    run_op(2'd3, 16'h0000, 128'd0, 128'd1, 1'b1, 1'b0, 1'b1);
    // R3: not writable, compare would fail anyway
    run_op(2'd1, 16'h0010, ~cur_val(2'd1, 16'h0010), 128'd3, 1'b1, 1'b1, 1'b0);
    // R8: failure with both ordering flags set
    run_op(2'd1, 16'h0018, ~cur_val(2'd1, 16'h0018), 128'd9, 1'b1, 1'b1, 1'b1);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      logic [15:0] a;
      logic [127:0] c;
      int opb;
      sz = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      opb = 4 << sz;
      a = 16'($urandom % 512);
      if ($urandom % 8 != 0) a = a & ~16'(opb - 1);
      c = (sz == 2'd3) ? 128'd0 : cur_val(sz, a & ~16'(opb - 1));
      case ($urandom % 4)
        0: c = {$urandom, $urandom, $urandom, $urandom};
        1: c = c ^ (128'd1 << ($urandom % 128));
        default: ;
      endcase
      run_op(sz, a, c, {$urandom, $urandom, $urandom, $urandom},
             1'($urandom), 1'($urandom), ($urandom % 10) != 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule